// File: doc/BRIEF.md
# Complementary Gate Command Generator with Selectable Non-Overlap

This block turns a single PWM input into two complementary gate commands for a half-bridge output stage. The high-side command follows the input polarity and the low-side command is its complement. Every change of state passes through an interval in which both commands are low. This non-overlap interval keeps the two power switches from conducting at the same time. Its length is one of four presets chosen by a 2-bit code. In the intended system that code comes from an external comparator bank that reads a configuration voltage.

The block counts every interval in clock cycles. The off-going command drops at the clock edge that samples the new input level. The on-coming command rises a fixed number of edges later, and the same count applies to both directions of transition. The preset length is captured when the input changes level and also throughout shutdown. A new code therefore never stretches or shortens an interval that is already running. An enable input drives both commands low for shutdown. When enable returns, a full interval must elapse before either command rises.

With the default parameters and a 5 ns clock, the presets correspond to 15, 25, 35 and 45 ns.

Top module: `nonoverlap_gate_gen`

## Requirements
- R1: Once a non-overlap interval has elapsed, `hs_cmd` equals `pwm_in` and `ls_cmd` equals its complement. `hs_cmd` only rises after an edge that sampled `pwm_in` high, and `ls_cmd` only rises after an edge that sampled it low.
- R2: Code `dt_code` 3 selects `DT_SHORTEST` (default 3 cycles), 2 selects `DT_SHORT` (5), 1 selects `DT_LONG` (7) and 0 selects `DT_LONGEST` (9). A higher code always gives a shorter interval.
- R3: The command that is on drops at the first edge that samples the opposite `pwm_in` level. The other command rises exactly D edges after that one, where D is the captured interval. This holds for both directions.
- R4: `hs_cmd` and `ls_cmd` are never high in the same cycle.
- R5: Suppose `pwm_in` returns to its previous level after w edges, where w ≤ D. Then the opposite command never rises, and the original command rises again D edges after it dropped.
- R6: The interval length is captured from `dt_code` at each edge where `pwm_in` differs from its previous sampled value, and at each edge where `enable` is low. A code change at any other time leaves a running interval unchanged.
- R7: An edge that samples `enable` low drives both commands low, whatever `pwm_in` does.
- R8: After shutdown, both commands stay low. The command chosen by `pwm_in` rises at the D-th edge that samples `enable` high, with D taken from the code present during shutdown.
- R9: During reset both commands are low and the captured interval is `DT_LONGEST`. After release without an input change or shutdown, the first turn-on comes at the `DT_LONGEST`-th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock for all interval counts |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM request; high asks for the high-side switch |
| enable | input | 1 | Low forces shutdown of both commands |
| dt_code | input | 2 | Non-overlap preset code (3 = shortest, 0 = longest) |
| hs_cmd | output | 1 | High-side gate command, in phase with `pwm_in` |
| ls_cmd | output | 1 | Low-side gate command, complement of `pwm_in` |

## Verification
For every preset code, the main test applies a single high pulse whose width sweeps from 1 to 12 cycles. It compares both commands cycle by cycle against the arithmetic expectation. Widths at or below the interval separate a suppressed pulse from a delivered one. Widths just above it show that the rise and the fall are both delayed by exactly D edges. A code change in the middle of an interval shows that the length was captured at the input edge and not read live. Shutdown entered with a command on, followed by recovery under a different code, separates the forced-off path and the restart count from ordinary switching. A reset with the shortest code applied separates the longest reset default from a value read live.

// File: rtl/nonoverlap_pkg.sv
package nonoverlap_pkg;

  typedef enum logic [1:0] {
    GAP_LONGEST  = 2'd0,
    GAP_LONG     = 2'd1,
    GAP_SHORT    = 2'd2,
    GAP_SHORTEST = 2'd3
  } gap_code_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned min4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/gap_length_latch.sv
module gap_length_latch
  import nonoverlap_pkg::*;
#(
  parameter int unsigned DT_SHORTEST = 3,
  parameter int unsigned DT_SHORT    = 5,
  parameter int unsigned DT_LONG     = 7,
  parameter int unsigned DT_LONGEST  = 9,
  parameter int unsigned CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [1:0]    code,
  output logic [CW-1:0] gap_len
);

  // Decode a preset code into a cycle count; higher code, shorter gap.
  function automatic logic [CW-1:0] code_to_cycles(input logic [1:0] c);
    logic [CW-1:0] r;
    case (gap_code_e'(c))
      GAP_SHORTEST: r = CW'(DT_SHORTEST);
      GAP_SHORT:    r = CW'(DT_SHORT);
      GAP_LONG:     r = CW'(DT_LONG);
      default:      r = CW'(DT_LONGEST);
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       gap_len <= CW'(DT_LONGEST);
    else if (capture) gap_len <= code_to_cycles(code);
  end

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] gap_len,
  output logic          gap_done
);

  localparam logic [CW-1:0] CNT_SAT = {CW{1'b1}};

  logic [CW-1:0] cnt;

  // Done when the edge being evaluated is the gap_len-th since restart.
  function automatic logic reached(input logic [CW-1:0] c, input logic [CW-1:0] len);
    return ({1'b0, c} + {{CW{1'b0}}, 1'b1}) >= {1'b0, len};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart)                cnt <= '0;
    else if (run && cnt != CNT_SAT)  cnt <= cnt + 1'b1;
  end

  assign gap_done = reached(cnt, gap_len);

endmodule

// File: rtl/nonoverlap_gate_gen.sv
module nonoverlap_gate_gen
  import nonoverlap_pkg::*;
#(
  parameter int unsigned DT_SHORTEST = 3,
  parameter int unsigned DT_SHORT    = 5,
  parameter int unsigned DT_LONG     = 7,
  parameter int unsigned DT_LONGEST  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       enable,
  input  logic [1:0] dt_code,
  output logic       hs_cmd,
  output logic       ls_cmd
);

  localparam int unsigned DT_MAX = max4(DT_SHORTEST, DT_SHORT, DT_LONG, DT_LONGEST);
  localparam int unsigned DT_MIN = min4(DT_SHORTEST, DT_SHORT, DT_LONG, DT_LONGEST);
  localparam int unsigned CW     = $clog2(DT_MAX + 1);

  logic          pwm_prev;
  logic          pwm_edge;
  logic          capture;
  logic          off_event;
  logic          both_low;
  logic          gap_done;
  logic          turn_on;
  logic [CW-1:0] gap_len;

  // Named events, also watched by the checker.
  assign pwm_edge  = pwm_in ^ pwm_prev;
  assign capture   = pwm_edge | ~enable;
  assign both_low  = ~hs_cmd & ~ls_cmd;
  assign off_event = enable & ((hs_cmd & ~pwm_in) | (ls_cmd & pwm_in));
  assign turn_on   = enable & both_low & gap_done;

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_prev <= 1'b0;
    else        pwm_prev <= pwm_in;
  end

  gap_length_latch #(
    .DT_SHORTEST (DT_SHORTEST),
    .DT_SHORT    (DT_SHORT),
    .DT_LONG     (DT_LONG),
    .DT_LONGEST  (DT_LONGEST),
    .CW          (CW)
  ) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .code    (dt_code),
    .gap_len (gap_len)
  );

  gap_timer #(
    .CW (CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (~enable | off_event),
    .run      (both_low),
    .gap_len  (gap_len),
    .gap_done (gap_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || off_event) begin
      hs_cmd <= 1'b0;
      ls_cmd <= 1'b0;
    end else if (turn_on) begin
      hs_cmd <= pwm_in;
      ls_cmd <= ~pwm_in;
    end
  end

endmodule

// File: rtl/nonoverlap_gate_chk.sv
module nonoverlap_gate_chk #(
  parameter int unsigned DT_MIN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_in,
  input logic enable,
  input logic hs_cmd,
  input logic ls_cmd,
  input logic off_event
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                    low_run <= '0;
    else if (hs_cmd || ls_cmd)     low_run <= '0;
    else if (low_run != 16'hFFFF)  low_run <= low_run + 16'd1;
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_cmd && ls_cmd));

  // R7
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_cmd && !ls_cmd));

  // R1
  hs_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_cmd) |-> $past(pwm_in));

  // R1
  ls_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_cmd) |-> !$past(pwm_in));

  // R3
  off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_event |=> (!hs_cmd && !ls_cmd));

  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_cmd) || $rose(ls_cmd)) |-> (low_run >= 16'(DT_MIN)));

endmodule

bind nonoverlap_gate_gen nonoverlap_gate_chk #(.DT_MIN(DT_MIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_in    (pwm_in),
  .enable    (enable),
  .hs_cmd    (hs_cmd),
  .ls_cmd    (ls_cmd),
  .off_event (off_event)
);

// File: tb/nonoverlap_gate_gen_tb.sv
`timescale 1ns/1ps
module nonoverlap_gate_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] dt_code = 2'd3;
  logic       hs_cmd;
  logic       ls_cmd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nonoverlap_gate_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_in  (pwm_in),
    .enable  (enable),
    .dt_code (dt_code),
    .hs_cmd  (hs_cmd),
    .ls_cmd  (ls_cmd)
  );

  // Preset interval in cycles, restated from R2: 9, 7, 5, 3 for codes 0..3.
  function automatic int gap_of(input int code);
    return 9 - 2 * code;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One pulse of width w on a steady low input; R1 R3 R4 R5
  task automatic run_pulse(input int code, input int w);
    int d;
    int ls_back;
    d = gap_of(code);
    @(negedge clk);
    dt_code = 2'(code);
    pwm_in  = 1'b0;
    idle(12);
    chk("R1 steady low side", ls_cmd, 1'b1);
    pwm_in = 1'b1;
    ls_back = (w > d) ? (w + d) : d;
    for (int j = 0; j <= w + d + 2; j++) begin
      @(negedge clk);
      if (w > d) chk("R3 high side timing", hs_cmd, (j >= d) && (j < w));
      else       chk("R5 short pulse suppressed", hs_cmd, 1'b0);
      chk("R3 low side timing", ls_cmd, j >= ls_back);
      chk("R4 no overlap", hs_cmd & ls_cmd, 1'b0);
      if (j == w - 1) pwm_in = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state, shortest code applied but longest interval expected
    enable  = 1'b1;
    dt_code = 2'd3;
    idle(3);
    chk("R9 reset hs low", hs_cmd, 1'b0);
    chk("R9 reset ls low", ls_cmd, 1'b0);
    rst_n = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R9 first turn-on uses longest", ls_cmd, k >= 9);
      chk("R9 hs stays low", hs_cmd, 1'b0);
    end

    // R2 R3 R5: sweep all codes and pulse widths
    for (int code = 0; code < 4; code++)
      for (int w = 1; w <= 12; w++)
        run_pulse(code, w);

    // R6: code change mid-interval has no effect (code 0 = 9 cycles)
    @(negedge clk);
    dt_code = 2'd0;
    pwm_in  = 1'b0;
    idle(12);
    pwm_in = 1'b1;
    for (int j = 0; j <= 10; j++) begin
      @(negedge clk);
      chk("R6 interval kept after code change", hs_cmd, j >= 9);
      if (j == 1) dt_code = 2'd3;
    end
    // R6/R2: the next input edge captures code 3 (3 cycles)
    pwm_in = 1'b0;
    for (int j = 0; j <= 4; j++) begin
      @(negedge clk);
      chk("R6 new code at next edge", ls_cmd, j >= 3);
    end

    // R7: shutdown with high side on, input toggling
    pwm_in = 1'b1;
    idle(8);
    chk("R1 high side on", hs_cmd, 1'b1);
    enable = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R7 shutdown hs", hs_cmd, 1'b0);
      chk("R7 shutdown ls", ls_cmd, 1'b0);
      pwm_in = ~pwm_in;
    end

    // R8: recover with code 2 (5 cycles) and input high
    dt_code = 2'd2;
    pwm_in  = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R8 restart after full interval", hs_cmd, k >= 5);
      chk("R8 ls stays low", ls_cmd, 1'b0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule